// File: doc/BRIEF.md
# CRT Horizontal Timing Generator

This block produces the horizontal timing of a character-based CRT controller. A character counter advances on each clock cycle where the character-clock enable is high. It wraps once per scan line. From the counter value and a set of configuration fields the block derives four outputs: display enable, horizontal blank, horizontal sync, and a one-cycle end-of-line pulse. The end-of-line pulse tells the vertical timing generator to advance.

The configuration fields come straight from the controller's register file, and the block samples them continuously:

- a total field and a display-end field;
- a blank start value and a 6-bit blank end value;
- a sync start value and a 5-bit sync end value;
- two 2-bit skew fields.

Blank and sync end points are matched on only the low 6 and 5 counter bits, so a pulse can run across the line wrap. The display skew and the sync skew postpone those two outputs by whole character clocks.

Top module: `crt_htiming`

## Requirements
- R1: The counter advances to the next count on each clock edge where `char_en_i` is high. It returns to 0 after count `htotal_i + 4`, so a line lasts `htotal_i + 5` character clocks. `line_end_o` is high for exactly the one clock cycle that follows the enabled edge on which the counter wrapped.
- R2: On a clock edge where `char_en_i` is low, the counter and every output hold their values, and `line_end_o` is low in the following cycle.
- R3: With `disp_skew_i` = 0, `disp_en_o` is high while the count is in 0 .. `hdisp_end_i` and low for the rest of the line.
- R4: A `disp_skew_i` value of N (0 to 3) makes `disp_en_o` show the zero-skew display state of N character clocks earlier.
- R5: `hblank_o` goes high when the count becomes equal to `hblank_start_i`.
- R6: `hblank_o` goes low when the low 6 bits of the count become equal to `hblank_end_i`. When the start match and the end match fall on the same count, the start match wins.
- R7: The zero-skew sync state goes high when the count becomes equal to `hsync_start_i`. It goes low when the low 5 bits of the count become equal to `hsync_end_i`, with the start match winning a tie.
- R8: `hsync_o` shows the zero-skew sync state delayed by `sync_skew_i` (0 to 3) character clocks.
- R9: While `rst_ni` is low, the count is 0 and `disp_en_o`, `hblank_o`, `hsync_o` and `line_end_o` are all low. All skew history is cleared to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_en_i | input | 1 | Character-clock enable |
| htotal_i | input | 8 | Line length minus 5, in character clocks |
| hdisp_end_i | input | 8 | Last count of active display |
| hblank_start_i | input | 8 | Count at which blanking starts |
| hblank_end_i | input | 6 | Low-6-bit count at which blanking ends |
| hsync_start_i | input | 8 | Count at which sync starts |
| hsync_end_i | input | 5 | Low-5-bit count at which sync ends |
| disp_skew_i | input | 2 | Display enable delay in character clocks |
| sync_skew_i | input | 2 | Sync delay in character clocks |
| disp_en_o | output | 1 | Display enable, active high |
| hblank_o | output | 1 | Horizontal blank, active high |
| hsync_o | output | 1 | Horizontal sync, active high |
| line_end_o | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench runs several complete lines under different configurations. It includes a line of the minimum length, and configurations whose blank and sync end matches fall after the line wraps. The character enable is driven in three ways: held high, alternating, and in a pseudo-random pattern.

A wrong count or a wrong wrap point shows up within one line, as an early or late `line_end_o` or display edge. A wrong span flop or a wrong skew tap shows up at the next start or end match, as an edge that is off by one or more character clocks. An enable that is not honoured shows up in the very next cycle.

// File: rtl/crt_htiming_pkg.sv
package crt_htiming_pkg;
  parameter int unsigned REG_W    = 8;
  parameter int unsigned CNT_W    = REG_W + 1;
  parameter int unsigned BEND_W   = 6;
  parameter int unsigned SEND_W   = 5;
  parameter int unsigned SKEW_W   = 2;
  parameter int unsigned LINE_ADD = 4;
endpackage

// File: rtl/crt_hcount.sv
module crt_hcount #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned LINE_ADD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [REG_W-1:0] total_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  assign last_cnt  = CNT_W'(total_i) + CNT_W'(LINE_ADD);
  assign at_last   = (cnt_q == last_cnt);
  assign cnt_nxt_o = at_last ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= step_i && at_last;
      if (step_i) cnt_q <= cnt_nxt_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/crt_hspan.sv
module crt_hspan #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned END_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [REG_W-1:0] start_i,
  input  logic [END_W-1:0] end_i,
  output logic             active_o
);
  logic hit_start;
  logic hit_end;

  assign hit_start = (pos_i == CNT_W'(start_i));
  assign hit_end   = (pos_i[END_W-1:0] == end_i);

  // start match has priority over end match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  active_o <= 1'b0;
    else if (step_i && hit_start) active_o <= 1'b1;
    else if (step_i && hit_end)   active_o <= 1'b0;
  end
endmodule

// File: rtl/crt_hskew.sv
module crt_hskew #(
  parameter int unsigned SKEW_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              in_i,
  input  logic [SKEW_W-1:0] sel_i,
  output logic              out_o
);
  localparam int unsigned DEPTH = (1 << SKEW_W) - 1;

  logic [DEPTH:0] taps;
  assign taps[0] = in_i;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     taps[k] <= 1'b0;
      else if (step_i) taps[k] <= taps[k-1];
    end
  end

  assign out_o = taps[sel_i];
endmodule

// File: rtl/crt_htiming.sv
module crt_htiming
  import crt_htiming_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_en_i,
  input  logic [REG_W-1:0]  htotal_i,
  input  logic [REG_W-1:0]  hdisp_end_i,
  input  logic [REG_W-1:0]  hblank_start_i,
  input  logic [BEND_W-1:0] hblank_end_i,
  input  logic [REG_W-1:0]  hsync_start_i,
  input  logic [SEND_W-1:0] hsync_end_i,
  input  logic [SKEW_W-1:0] disp_skew_i,
  input  logic [SKEW_W-1:0] sync_skew_i,
  output logic              disp_en_o,
  output logic              hblank_o,
  output logic              hsync_o,
  output logic              line_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             disp_q;
  logic             sync_q;

  crt_hcount #(.REG_W(REG_W), .CNT_W(CNT_W), .LINE_ADD(LINE_ADD)) u_cnt (
    .clk_i, .rst_ni, .step_i(char_en_i), .total_i(htotal_i),
    .cnt_o(cnt_q), .cnt_nxt_o(cnt_nxt), .wrap_o(line_end_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        disp_q <= 1'b0;
    else if (char_en_i) disp_q <= (cnt_nxt <= CNT_W'(hdisp_end_i));
  end

  crt_hspan #(.REG_W(REG_W), .CNT_W(CNT_W), .END_W(BEND_W)) u_blank (
    .clk_i, .rst_ni, .step_i(char_en_i), .pos_i(cnt_nxt),
    .start_i(hblank_start_i), .end_i(hblank_end_i), .active_o(hblank_o)
  );

  crt_hspan #(.REG_W(REG_W), .CNT_W(CNT_W), .END_W(SEND_W)) u_sync (
    .clk_i, .rst_ni, .step_i(char_en_i), .pos_i(cnt_nxt),
    .start_i(hsync_start_i), .end_i(hsync_end_i), .active_o(sync_q)
  );

  crt_hskew #(.SKEW_W(SKEW_W)) u_disp_skew (
    .clk_i, .rst_ni, .step_i(char_en_i), .in_i(disp_q),
    .sel_i(disp_skew_i), .out_o(disp_en_o)
  );

  crt_hskew #(.SKEW_W(SKEW_W)) u_sync_skew (
    .clk_i, .rst_ni, .step_i(char_en_i), .in_i(sync_q),
    .sel_i(sync_skew_i), .out_o(hsync_o)
  );
endmodule

// File: rtl/crt_htiming_chk.sv
module crt_htiming_chk
  import crt_htiming_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_en_i,
  input logic             hblank_o,
  input logic             line_end_o,
  input logic [CNT_W-1:0] cnt_q
);
  // R1
  line_end_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |-> (cnt_q == '0));

  // R1
  line_end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> !line_end_o);

  // R2
  idle_no_line_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_en_i |=> !line_end_o);

  // R2
  idle_blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_en_i |=> $stable(hblank_o));

  // R2
  idle_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_en_i |=> $stable(cnt_q));
endmodule

bind crt_htiming crt_htiming_chk u_chk (
  .clk_i, .rst_ni, .char_en_i, .hblank_o, .line_end_o, .cnt_q
);

// File: tb/crt_htiming_test.sv
`timescale 1ns/1ps
module crt_htiming_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       char_en_i = 1'b0;
  logic [7:0] htotal_i = '0, hdisp_end_i = '0, hblank_start_i = '0, hsync_start_i = '0;
  logic [5:0] hblank_end_i = '0;
  logic [4:0] hsync_end_i = '0;
  logic [1:0] disp_skew_i = '0, sync_skew_i = '0;
  logic       disp_en_o, hblank_o, hsync_o, line_end_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int p;
  bit hd[4];
  bit hr[4];
  bit mb, mr, ml;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk_i = ~clk_i;

  crt_htiming uut (.*);

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    p = 0; mb = 0; mr = 0; ml = 0;
    for (int k = 0; k < 4; k++) begin hd[k] = 0; hr[k] = 0; end
  endtask

  task automatic model_step(bit en);
    int len;
    len = int'(htotal_i) + 5;
    ml = 0;
    if (!en) return;
    ml = (p == len - 1);
    p = ml ? 0 : p + 1;
    for (int k = 3; k > 0; k--) begin hd[k] = hd[k-1]; hr[k] = hr[k-1]; end
    hd[0] = (p <= int'(hdisp_end_i));
    if (p == int'(hblank_start_i)) mb = 1;
    else if ((p % 64) == int'(hblank_end_i)) mb = 0;
    if (p == int'(hsync_start_i)) mr = 1;
    else if ((p % 32) == int'(hsync_end_i)) mr = 0;
    hr[0] = mr;
  endtask

  task automatic compare(bit en_prev);
    string t;
    t = en_prev ? "R1" : "R2";
    check(t, line_end_o, ml);
    t = (disp_skew_i == 0) ? "R3" : "R4";
    check(en_prev ? t : "R2", disp_en_o, hd[disp_skew_i]);
    check(en_prev ? "R5,R6" : "R2", hblank_o, mb);
    t = (sync_skew_i == 0) ? "R7" : "R8";
    check(en_prev ? t : "R2", hsync_o, hr[sync_skew_i]);
  endtask

  task automatic run_cfg(int ht, int de, int bs, int be, int ss, int se,
                         int dk, int sk, int mode, int cycles);
    bit en;
    @(negedge clk_i);
    rst_ni = 1'b0;
    char_en_i = 1'b0;
    htotal_i = 8'(ht); hdisp_end_i = 8'(de);
    hblank_start_i = 8'(bs); hblank_end_i = 6'(be);
    hsync_start_i = 8'(ss); hsync_end_i = 5'(se);
    disp_skew_i = 2'(dk); sync_skew_i = 2'(sk);
    model_reset();
    @(negedge clk_i);
    // R9
    check("R9", disp_en_o, 1'b0);
    check("R9", hblank_o, 1'b0);
    check("R9", hsync_o, 1'b0);
    check("R9", line_end_o, 1'b0);
    rst_ni = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      case (mode)
        0: en = 1'b1;
        1: en = c[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          en = lfsr[0] | lfsr[3];
        end
      endcase
      char_en_i = en;
      model_step(en);
      @(negedge clk_i);
      compare(en);
    end
  endtask

  initial begin
    model_reset();
    // basic line, no skew, blank end after wrap
    run_cfg(20, 15, 17, 3, 19, 22, 0, 0, 0, 80);
    // same line with skews, enable every other cycle
    run_cfg(20, 15, 17, 3, 19, 22, 2, 3, 1, 160);
    // longer line: end matches on low bits only
    run_cfg(70, 63, 60, 5, 50, 28, 1, 1, 2, 400);
    // minimum line length, start/end tie on blank
    run_cfg(0, 1, 2, 2, 3, 0, 3, 2, 0, 40);
    // display covers whole line, sync tie
    run_cfg(10, 200, 12, 12, 4, 4, 3, 0, 2, 120);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule